// File: doc/BRIEF.md
# SPI Interrupt Status Unit

This block holds the interrupt state of a byte-oriented SPI master. A 7-bit status word mixes two kinds of bits: event bits, which latch when the datapath raises a strobe and hold until software writes 1 to them, and level bits, which are recomputed every clock from the transmit and receive FIFO occupancy counts against their full depth and two programmable thresholds. A 7-bit mask selects which status bits may raise the single level-sensitive interrupt output. Software cannot write the mask directly. It changes the mask only through an enable register, which sets bits, and a disable register, which clears them.

The datapath supplies the two FIFO counts and three one-cycle event strobes. Software reaches the block through a small register port with a single-cycle write strobe and a read strobe. Read data is returned one cycle after the strobe. The serial shifter and the FIFOs themselves sit outside this block.

Top module: `spi_irq_unit`

## Requirements
- R1: Status bit positions are: 6 TX underflow, 5 RX full, 4 RX at-threshold, 3 TX full, 2 TX below-threshold, 1 mode fail, 0 RX overflow. A one-cycle strobe on `tx_underflow_evt`, `mode_fail_evt` or `rx_overflow_evt` sets bit 6, 1 or 0 at the next clock edge.
- R2: Event bits 6, 1 and 0 stay set until a write to the status register (address 0) carries 1 in that bit position. Written 0s leave them unchanged.
- R3: When an event strobe and a status write that clears the same bit arrive in the same cycle, the bit ends up set.
- R4: Bit 5 is 1 exactly when `rx_count` equals DEPTH, and bit 3 is 1 exactly when `tx_count` equals DEPTH. Both are recomputed every clock, so status writes have no lasting effect on them.
- R5: Bit 4 is 1 when `rx_count` >= the RX threshold (address 5). Bit 2 is 1 when `tx_count` < the TX threshold (address 4). Both bits update one clock after a count or threshold changes.
- R6: A write to address 1 ORs `reg_wdata[6:0]` into the mask. A write to address 2 clears the mask bits written as 1. A write to the mask address 3 leaves the mask unchanged.
- R7: `irq` is registered and equals the OR over bits 6..0 of (mask AND status), one clock after the status or mask value.
- R8: Reads return data on `reg_rdata` in the cycle after `reg_rd`. Addresses 1, 2, 6 and 7 read as zero. Address 0 returns the status word, address 3 the mask, and addresses 4 and 5 the TX and RX thresholds.
- R9: Synchronous reset clears the mask, the event bits and `irq`, and sets both thresholds to 1. With empty FIFOs, status reads 0x04 after reset.
- R10: A threshold register keeps the low CNT_W bits of the write data (6 bits when DEPTH is 32), so the value DEPTH can be stored. With RX threshold 32, bit 4 is set only when the RX FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_underflow_evt | input | 1 | TX underflow event strobe |
| mode_fail_evt | input | 1 | Mode fail event strobe |
| rx_overflow_evt | input | 1 | RX overflow event strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The one real collision is a sticky event arriving in the same cycle as a software write that clears that bit. The bench provokes it by driving `rx_overflow_evt` and a status write with bit 0 set on the same clock. It then expects bit 0 to read back as set, and expects a later write on its own to clear it. A second overlap is a status write that tries to clear the level bits while the FIFO counts still hold them true; the bench checks that the recomputed value wins. Separate checks measure when `irq` changes, one clock after the status or mask update.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  localparam int STAT_W = 7;

  // Register addresses
  localparam logic [2:0] A_STATUS  = 3'd0;
  localparam logic [2:0] A_ENABLE  = 3'd1;
  localparam logic [2:0] A_DISABLE = 3'd2;
  localparam logic [2:0] A_MASK    = 3'd3;
  localparam logic [2:0] A_TX_THR  = 3'd4;
  localparam logic [2:0] A_RX_THR  = 3'd5;

  // Status bit positions
  localparam int B_RX_OVF   = 0;
  localparam int B_MODEFAIL = 1;
  localparam int B_TX_LOW   = 2;
  localparam int B_TX_FULL  = 3;
  localparam int B_RX_AVAIL = 4;
  localparam int B_RX_FULL  = 5;
  localparam int B_TX_UNF   = 6;

  // Bits that latch on an event and clear on write-one
  localparam logic [STAT_W-1:0] STICKY_BITS =
    STAT_W'((1 << B_TX_UNF) | (1 << B_MODEFAIL) | (1 << B_RX_OVF));

endpackage

// File: rtl/spi_irq_cfg_reg.sv
module spi_irq_cfg_reg #(
  parameter int          W         = 6,
  parameter int          DATA_W    = 8,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [W-1:0]      q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= RESET_VAL;
    else if (we) q <= wdata[W-1:0];
  end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_bits,
  input  logic [STAT_W-1:0] evt_bits,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_thr,
  input  logic [CNT_W-1:0]  rx_thr,
  output logic [STAT_W-1:0] status_q
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [STAT_W-1:0] level_now;
  logic [STAT_W-1:0] clr_eff;

  always_comb begin
    level_now             = '0;
    level_now[B_RX_FULL]  = (rx_count == FULL_CNT);
    level_now[B_RX_AVAIL] = (rx_count >= rx_thr);
    level_now[B_TX_FULL]  = (tx_count == FULL_CNT);
    level_now[B_TX_LOW]   = (tx_count <  tx_thr);
    clr_eff               = clr_we ? clr_bits : '0;
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (STICKY_BITS[b]) begin : g_sticky
      // event has priority over a concurrent clear
      always_ff @(posedge clk) begin
        if (rst)              status_q[b] <= 1'b0;
        else if (evt_bits[b]) status_q[b] <= 1'b1;
        else if (clr_eff[b])  status_q[b] <= 1'b0;
      end
    end else begin : g_level
      always_ff @(posedge clk) begin
        if (rst) status_q[b] <= 1'b0;
        else     status_q[b] <= level_now[b];
      end
    end
  end

endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
  import spi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] bits,
  output logic [STAT_W-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst)         mask_q <= '0;
    else if (set_we) mask_q <= mask_q | bits;
    else if (clr_we) mask_q <= mask_q & ~bits;
  end

endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              tx_underflow_evt,
  input  logic              mode_fail_evt,
  input  logic              rx_overflow_evt,
  output logic              irq
);

  localparam int N_THR = 2;

  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] evt_bits;
  logic [STAT_W-1:0] wbits;
  logic [CNT_W-1:0]  thr_q [N_THR];
  logic [CNT_W-1:0]  tx_thr_q;
  logic [CNT_W-1:0]  rx_thr_q;
  logic              wr_status, wr_enable, wr_disable;

  always_comb begin
    wbits                = reg_wdata[STAT_W-1:0];
    wr_status            = reg_wr && (reg_addr == ADDR_W'(A_STATUS));
    wr_enable            = reg_wr && (reg_addr == ADDR_W'(A_ENABLE));
    wr_disable           = reg_wr && (reg_addr == ADDR_W'(A_DISABLE));
    evt_bits             = '0;
    evt_bits[B_TX_UNF]   = tx_underflow_evt;
    evt_bits[B_MODEFAIL] = mode_fail_evt;
    evt_bits[B_RX_OVF]   = rx_overflow_evt;
  end

  // Threshold registers: index 0 = TX, index 1 = RX
  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(A_TX_THR) + ADDR_W'(g);
    spi_irq_cfg_reg #(
      .W        (CNT_W),
      .DATA_W   (DATA_W),
      .RESET_VAL(CNT_W'(1))
    ) u_thr (
      .clk  (clk),
      .rst  (rst),
      .we   (reg_wr && (reg_addr == MY_ADDR)),
      .wdata(reg_wdata),
      .q    (thr_q[g])
    );
  end

  assign tx_thr_q = thr_q[0];
  assign rx_thr_q = thr_q[1];

  spi_irq_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_status (
    .clk     (clk),
    .rst     (rst),
    .clr_we  (wr_status),
    .clr_bits(wbits),
    .evt_bits(evt_bits),
    .tx_count(tx_count),
    .rx_count(rx_count),
    .tx_thr  (tx_thr_q),
    .rx_thr  (rx_thr_q),
    .status_q(status_q)
  );

  spi_irq_mask u_mask (
    .clk   (clk),
    .rst   (rst),
    .set_we(wr_enable),
    .clr_we(wr_disable),
    .bits  (wbits),
    .mask_q(mask_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(mask_q & status_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        ADDR_W'(A_STATUS): reg_rdata <= DATA_W'(status_q);
        ADDR_W'(A_MASK):   reg_rdata <= DATA_W'(mask_q);
        ADDR_W'(A_TX_THR): reg_rdata <= DATA_W'(tx_thr_q);
        ADDR_W'(A_RX_THR): reg_rdata <= DATA_W'(rx_thr_q);
        default:           reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
  import spi_irq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [CNT_W-1:0]  rx_count,
  input logic              tx_underflow_evt,
  input logic              rx_overflow_evt,
  input logic [STAT_W-1:0] status_q,
  input logic [STAT_W-1:0] mask_q,
  input logic              irq
);

  logic clr0, clr6;
  assign clr0 = reg_wr && reg_addr == ADDR_W'(A_STATUS) && reg_wdata[B_RX_OVF];
  assign clr6 = reg_wr && reg_addr == ADDR_W'(A_STATUS) && reg_wdata[B_TX_UNF];

  a_r1_underflow_sets: assert property (@(posedge clk) disable iff (rst)
    tx_underflow_evt |=> status_q[B_TX_UNF]);

  a_r3_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
    rx_overflow_evt |=> status_q[B_RX_OVF]);

  a_r2_ovf_holds: assert property (@(posedge clk) disable iff (rst)
    (status_q[B_RX_OVF] && !clr0) |=> status_q[B_RX_OVF]);

  a_r2_unf_holds: assert property (@(posedge clk) disable iff (rst)
    (status_q[B_TX_UNF] && !clr6) |=> status_q[B_TX_UNF]);

  a_r4_rx_full: assert property (@(posedge clk) disable iff (rst)
    (rx_count == CNT_W'(DEPTH)) |=> status_q[B_RX_FULL]);

  a_r6_enable_sets: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(A_ENABLE)) |=>
      ((mask_q & $past(reg_wdata[STAT_W-1:0])) == $past(reg_wdata[STAT_W-1:0])));

  a_r6_mask_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(A_MASK)) |=> $stable(mask_q));

  a_r7_irq_high: assert property (@(posedge clk) disable iff (rst)
    (|(mask_q & status_q)) |=> irq);

  a_r7_irq_low: assert property (@(posedge clk) disable iff (rst)
    !(|(mask_q & status_q)) |=> !irq);

  a_r8_write_only_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (reg_addr == ADDR_W'(A_ENABLE) || reg_addr == ADDR_W'(A_DISABLE)))
      |=> (reg_rdata == '0));

endmodule

bind spi_irq_unit spi_irq_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .reg_wr          (reg_wr),
  .reg_rd          (reg_rd),
  .reg_addr        (reg_addr),
  .reg_wdata       (reg_wdata),
  .reg_rdata       (reg_rdata),
  .rx_count        (rx_count),
  .tx_underflow_evt(tx_underflow_evt),
  .rx_overflow_evt (rx_overflow_evt),
  .status_q        (status_q),
  .mask_q          (mask_q),
  .irq             (irq)
);

// File: tb/spi_irq_unit_bench.sv
module spi_irq_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 32;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int NVEC   = 7;

  // {tx_count, rx_count, tx_thr, rx_thr, expected level bits 5..2}
  localparam logic [30:0] VEC [NVEC] = '{
    {6'd0,  6'd0,  6'd1,  6'd1,  7'h04},
    {6'd32, 6'd32, 6'd1,  6'd1,  7'h38},
    {6'd5,  6'd5,  6'd6,  6'd6,  7'h04},
    {6'd6,  6'd6,  6'd6,  6'd6,  7'h10},
    {6'd31, 6'd31, 6'd32, 6'd32, 7'h04},
    {6'd0,  6'd32, 6'd32, 6'd32, 7'h34},
    {6'd10, 6'd0,  6'd0,  6'd0,  7'h10}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [CNT_W-1:0]  tx_count = '0;
  logic [CNT_W-1:0]  rx_count = '0;
  logic              tx_underflow_evt = 1'b0;
  logic              mode_fail_evt = 1'b0;
  logic              rx_overflow_evt = 1'b0;
  logic              irq;

  int n_checks = 0;
  int n_fails  = 0;
  logic [DATA_W-1:0] rv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_irq_unit #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_spi_irq_unit (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_count(tx_count),
    .rx_count(rx_count), .tx_underflow_evt(tx_underflow_evt),
    .mode_fail_evt(mode_fail_evt), .rx_overflow_evt(rx_overflow_evt), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: rx_overflow_evt = 1'b1;
      1: mode_fail_evt = 1'b1;
      default: tx_underflow_evt = 1'b1;
    endcase
    @(negedge clk);
    rx_overflow_evt = 1'b0; mode_fail_evt = 1'b0; tx_underflow_evt = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R9: reset state
    check("R9 irq after reset", irq, 0);
    rd(3'd0, rv); check("R9 status after reset", rv, 8'h04);
    rd(3'd3, rv); check("R9 mask after reset", rv, 8'h00);
    rd(3'd4, rv); check("R9 tx threshold reset", rv, 8'h01);
    rd(3'd5, rv); check("R9 rx threshold reset", rv, 8'h01);

    // R4 / R5 / R10: level bits from the vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(3'd4, {2'b00, VEC[i][18:13]});
      wr(3'd5, {2'b00, VEC[i][12:7]});
      @(negedge clk);
      tx_count = VEC[i][30:25];
      rx_count = VEC[i][24:19];
      repeat (2) @(negedge clk);
      rd(3'd0, rv);
      check($sformatf("R4/R5 vector %0d", i), rv & 8'h3C, {1'b0, VEC[i][6:0]});
    end
    @(negedge clk);
    tx_count = '0; rx_count = '0;

    // R10: threshold keeps low 6 bits
    wr(3'd4, 8'hFF);
    rd(3'd4, rv); check("R10 tx threshold truncation", rv, 8'h3F);
    wr(3'd5, 8'd32);
    rd(3'd5, rv); check("R10 rx threshold holds 32", rv, 8'd32);
    wr(3'd4, 8'd1);
    wr(3'd5, 8'd1);
    repeat (2) @(negedge clk);

    // R1: events set sticky bits
    pulse(0); rd(3'd0, rv); check("R1 rx overflow sets bit0", rv, 8'h05);
    pulse(1); rd(3'd0, rv); check("R1 mode fail sets bit1", rv, 8'h07);
    pulse(2); rd(3'd0, rv); check("R1 tx underflow sets bit6", rv, 8'h47);

    // R2: write-one clears, sticky hold
    wr(3'd0, 8'h02); rd(3'd0, rv); check("R2 clear bit1 only", rv, 8'h45);
    repeat (3) @(negedge clk);
    rd(3'd0, rv); check("R2 sticky bits hold", rv, 8'h45);
    // R4: level bits cannot be cleared by a write
    wr(3'd0, 8'h3C); rd(3'd0, rv); check("R4 level bits recomputed", rv, 8'h45);

    // R3: event and clear in the same cycle
    @(negedge clk);
    rx_overflow_evt = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h01;
    @(negedge clk);
    rx_overflow_evt = 1'b0; reg_wr = 1'b0;
    rd(3'd0, rv); check("R3 event wins over clear", rv, 8'h45);
    wr(3'd0, 8'h41); rd(3'd0, rv); check("R3 later clear works", rv, 8'h04);

    // R6 / R8: mask through enable and disable
    wr(3'd1, 8'h05); rd(3'd3, rv); check("R6 enable sets mask", rv, 8'h05);
    rd(3'd1, rv); check("R8 enable reads zero", rv, 8'h00);
    rd(3'd2, rv); check("R8 disable reads zero", rv, 8'h00);
    rd(3'd7, rv); check("R8 unmapped reads zero", rv, 8'h00);
    wr(3'd3, 8'h7F); rd(3'd3, rv); check("R6 mask write ignored", rv, 8'h05);
    wr(3'd2, 8'h04); rd(3'd3, rv); check("R6 disable clears mask", rv, 8'h01);

    // R7: irq timing
    @(negedge clk);
    check("R7 irq low before event", irq, 0);
    rx_overflow_evt = 1'b1;
    @(negedge clk);
    rx_overflow_evt = 1'b0;
    check("R7 irq not yet high", irq, 0);
    @(negedge clk);
    check("R7 irq high one clock later", irq, 1);
    wr(3'd2, 8'h01);
    check("R7 irq still high at mask clear", irq, 1);
    @(negedge clk);
    check("R7 irq low after mask clear", irq, 0);
    wr(3'd1, 8'h04);
    @(negedge clk);
    check("R7 irq from level bit", irq, 1);

    finish_run();
  end

endmodule